// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on into a usable state. After reset it holds the command bus idle with clock enable high for a programmable settling period. It then closes every bank with one precharge, issues a configurable number of auto refresh commands (two or more), and writes the mode register with a fixed mode word. Each command is followed by its own NOP gap. When the gap after the mode load has passed, `done` rises and the command bus is handed to the main memory controller.

All timing values are parameters counted in clock cycles: the settling wait, the precharge-to-refresh gap, the refresh-to-next-command gap and the mode-load-to-ready gap. The state machine has eight states:

- `ST_WAIT`: settling wait.
- `ST_PRE`: precharge issue.
- `ST_PRE_GAP`: gap after the precharge.
- `ST_REF`: refresh issue.
- `ST_REF_GAP`: gap after a refresh.
- `ST_MRS`: mode load issue.
- `ST_MRS_GAP`: gap after the mode load.
- `ST_DONE`: sequence complete.

The transitions are:

- `WAIT→PRE` when the settling timer expires.
- `PRE→PRE_GAP` and `REF→REF_GAP` and `MRS→MRS_GAP` after one issue cycle.
- `PRE_GAP→REF` when the timer expires.
- `REF_GAP→REF` when the timer expires and refreshes remain.
- `REF_GAP→MRS` when the timer expires and no refreshes remain.
- `MRS_GAP→DONE` when the timer expires.

Reset from any state returns the machine to `ST_WAIT`.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst` is high, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `done` is low and `cke` is high.
- R2: For the first `T_STABLE` cycles after reset release (cycles 0 to T_STABLE-1), the command is NOP and `cke` is high.
- R3: At cycle `T_STABLE`, exactly one precharge-all is issued. The pins are 0010 and address bit `AP_BIT` (bit 10) is 1.
- R4: Exactly `REF_COUNT` auto refresh commands (pins 0001) are issued. The first comes `T_RP` cycles after the precharge and each following one comes `T_RFC` cycles after the previous. Every cycle in between shows NOP.
- R5: A mode-register load (pins 0000) is issued `T_RFC` cycles after the last refresh. It drives `addr` = `MODE_WORD` and `ba` = 0.
- R6: `done` rises exactly `T_MRD` cycles after the mode load and stays high. From then on, every command is NOP.
- R7: Reset asserted at any point, including mid-sequence or after `done`, restarts the whole script from cycle 0.
- R8: `cke` is high in every cycle.
- R9: No command other than the scripted ones appears. The total order is wait, precharge, refreshes, mode load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| cke | output | 1 | Clock enable to the DRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (mode word, precharge-all bit) |
| ba | output | BANK_W | Bank address, always 0 |
| done | output | 1 | Initialization complete |

## Verification
The bench compares every pin in every cycle against a schedule computed from the parameters. A wrong state or a mis-loaded timer therefore shows up in the very cycle the first command is early, late, missing or duplicated.

A wrong refresh count shifts the mode load by a multiple of `T_RFC`. A bad mode-word path shows on `addr` during the mode-load cycle. A faulty reset path shows as a missing restart within one cycle of `rst`.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PRE,
        ST_PRE_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_MRS,
        ST_MRS_GAP,
        ST_DONE
    } init_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } init_cmd_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP = 4'b0111;
    localparam cmd_pins_t PINS_PRE = 4'b0010;
    localparam cmd_pins_t PINS_REF = 4'b0001;
    localparam cmd_pins_t PINS_MRS = 4'b0000;

    function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    localparam logic [W-1:0] RST_CNT = RST_VAL[W-1:0];

    logic [W-1:0] count;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            count <= RST_CNT;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && count == '0) |=> (count == '0)); // R4

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
    import sdr_init_pkg::*;
(
    input  init_cmd_t cmd,
    output cmd_pins_t pins
);

    always_comb begin
        unique case (cmd)
            CMD_NOP: pins = PINS_NOP;
            CMD_PRE: pins = PINS_PRE;
            CMD_REF: pins = PINS_REF;
            CMD_MRS: pins = PINS_MRS;
            default: pins = PINS_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdr_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned AP_BIT    = 10,
    parameter int unsigned T_STABLE  = 10000,
    parameter int unsigned REF_COUNT = 2,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RFC     = 7,
    parameter int unsigned T_MRD     = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = 11'b000_0_00_010_0_011
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              done
);

    localparam int unsigned GAP_MAX = max_of4(T_STABLE, T_RP, T_RFC, T_MRD);
    localparam int unsigned TW      = $clog2(GAP_MAX + 1);
    localparam int unsigned RW      = $clog2(REF_COUNT + 1);
    localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 2);
    localparam logic [TW-1:0] LD_RFC = TW'(T_RFC - 2);
    localparam logic [TW-1:0] LD_MRD = TW'(T_MRD - 2);
    localparam logic [RW-1:0] REF_LEFT_INIT = RW'(REF_COUNT - 1);
    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    init_state_t     state, state_nx;
    logic [RW-1:0]   ref_left;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_exp;
    init_cmd_t       cmd;
    cmd_pins_t       pins;

    init_gap_timer #(.W(TW), .RST_VAL(T_STABLE - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // state register and refresh counter
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state    <= ST_WAIT;
            ref_left <= REF_LEFT_INIT;
        end else begin
            state <= state_nx;
            if (state == ST_REF_GAP && tmr_exp && ref_left != '0) begin
                ref_left <= ref_left - 1'b1;
            end
        end
    end

    // next state and timer loading
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_WAIT:    if (tmr_exp) state_nx = ST_PRE;
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
                state_nx = ST_PRE_GAP;
            end
            ST_PRE_GAP: if (tmr_exp) state_nx = ST_REF;
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
                state_nx = ST_REF_GAP;
            end
            ST_REF_GAP: begin
                if (tmr_exp) state_nx = (ref_left == '0) ? ST_MRS : ST_REF;
            end
            ST_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
                state_nx = ST_MRS_GAP;
            end
            ST_MRS_GAP: if (tmr_exp) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_DONE;
            default:    state_nx = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        unique case (state)
            ST_PRE: begin
                cmd  = CMD_PRE;
                addr = AP_MASK;
            end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = MODE_WORD;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    init_cmd_drive u_drive (
        .cmd  (cmd),
        .pins (pins)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign ba    = '0;
    assign cke   = 1'b1;
    assign done  = (state == ST_DONE);

    // checking
    logic [RW:0] ref_seen;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) ref_seen <= '0;
        else if (pins == PINS_REF) ref_seen <= ref_seen + 1'b1;
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R6
    AST_NOP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (pins == PINS_NOP)); // R6
    AST_PRE_ALL_BIT: assert property (@(posedge clk) disable iff (rst)
        (pins == PINS_PRE) |-> addr[AP_BIT]); // R3
    AST_PRE_BEFORE_REF: assert property (@(posedge clk) disable iff (rst)
        (pins == PINS_PRE) |-> (ref_seen == '0)); // R9
    AST_MRS_WORD: assert property (@(posedge clk) disable iff (rst)
        (pins == PINS_MRS) |-> (addr == MODE_WORD && ba == '0)); // R5
    AST_MRS_AFTER_REFS: assert property (@(posedge clk) disable iff (rst)
        (pins == PINS_MRS) |-> (ref_seen == (RW+1)'(REF_COUNT))); // R4
    AST_REF_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
        (pins == PINS_REF) |=> (pins == PINS_NOP)); // R4
    AST_DONE_AFTER_MRS: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (ref_seen == (RW+1)'(REF_COUNT))); // R6

endmodule

// File: tb/test_sdram_powerup_seq.sv
module test_sdram_powerup_seq;

    localparam int T_STABLE  = 10;
    localparam int REF_COUNT = 3;
    localparam int T_RP      = 3;
    localparam int T_RFC     = 5;
    localparam int T_MRD     = 2;
    localparam logic [10:0] MODE = 11'b010_0011_0101;
    localparam int K_PRE  = T_STABLE;
    localparam int K_REF0 = K_PRE + T_RP;
    localparam int K_MRS  = K_REF0 + REF_COUNT * T_RFC;
    localparam int K_DONE = K_MRS + T_MRD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [10:0] addr;
    logic [1:0]  ba;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdram_powerup_seq #(
        .T_STABLE(T_STABLE), .REF_COUNT(REF_COUNT), .T_RP(T_RP),
        .T_RFC(T_RFC), .T_MRD(T_MRD), .MODE_WORD(MODE)
    ) i_sdram_powerup_seq (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .done(done)
    );

    task automatic check(string req, int k, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, k, act, exp);
        end
    endtask

    // compare every pin against the arithmetic schedule for cycle k
    task automatic check_cycle(int k);
        logic [3:0] exp_pins;
        string req;
        exp_pins = 4'b0111;
        req = (k < K_PRE) ? "R2" : "R9";
        if (k == K_PRE) begin
            exp_pins = 4'b0010; req = "R3";
        end else if (k >= K_REF0 && k < K_MRS && ((k - K_REF0) % T_RFC) == 0) begin
            exp_pins = 4'b0001; req = "R4";
        end else if (k == K_MRS) begin
            exp_pins = 4'b0000; req = "R5";
        end else if (k > K_MRS) begin
            req = "R6";
        end
        check(req, k, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, exp_pins});
        check("R8", k, {31'd0, cke}, 32'd1);
        check("R6", k, {31'd0, done}, {31'd0, (k >= K_DONE)});
        if (k == K_PRE) check("R3", k, {31'd0, addr[10]}, 32'd1);
        if (k == K_MRS) begin
            check("R5", k, {21'd0, addr}, {21'd0, MODE});
            check("R5", k, {30'd0, ba}, 32'd0);
        end
    endtask

    task automatic check_reset_state();
        check("R1", -1, {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
        check("R1", -1, {31'd0, done}, 32'd0);
        check("R1", -1, {31'd0, cke}, 32'd1);
    endtask

    // release reset and sweep cycles 0..last
    task automatic sweep(int last, string tag);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_cycle(0);
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            #1;
            check_cycle(k);
        end
        if (tag.len() > 0) check(tag, last, 32'd1, 32'd1);
    endtask

    task automatic apply_reset(int n);
        @(negedge clk);
        rst = 1'b1;
        #1;
        check_reset_state();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            check_reset_state();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #2;
        check_reset_state();
        repeat (3) @(negedge clk);
        #1;
        check_reset_state();

        // full sweep, R2..R6, R8, R9
        sweep(K_DONE + 6, "");

        // R7: reset after done, then full restart
        apply_reset(2);
        sweep(K_DONE + 4, "R7");

        // R7: reset in the middle of the refresh phase
        apply_reset(1);
        sweep(K_MRS - 2, "");
        apply_reset(3);
        sweep(K_DONE + 4, "R7");

        // R7: reset during the stabilization wait
        apply_reset(1);
        sweep(T_STABLE - 3, "");
        apply_reset(1);
        sweep(K_DONE + 2, "R7");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule